// File: doc/BRIEF.md
# Single-Clock FIFO with Programmable Fill Flags

This block is a single-clock first-in first-out buffer for 18-bit words. Its depth is a parameter that takes 256 or 512 words. Four active-low level flags report the fill level: empty, full, almost-empty and almost-full. The almost-empty and almost-full thresholds come from two offset registers that software loads at run time. All four flags are decoded from the registered word count. A flag therefore moves in the cycle after the push or pop that changed the count.

Each offset register is loaded from an 18-bit word through a load strobe, and a select input picks the target register. Only the low nine bits of the word carry the offset. The upper bits are discarded. When the depth is 256, bit 8 of the offset is forced to zero, so a programmed offset can never reach the depth. A small fill-state machine with the states EMPTY, PARTIAL and FULL gates the strobes. In EMPTY a pop is refused. In FULL a push is refused. In PARTIAL both are accepted. The transitions are:
- EMPTY to PARTIAL on an accepted push.
- PARTIAL to EMPTY when the last word leaves.
- PARTIAL to FULL when the last free slot is filled.
- FULL to PARTIAL on an accepted pop.

Top module: `prog_flag_fifo`

## Requirements
- R1: After reset the FIFO holds no words. `dout` is 0. Both offset registers hold 7. The flags are `empty_n`=0, `almost_empty_n`=0, `almost_full_n`=1 and `full_n`=1.
- R2: `empty_n` is 0 when the count is 0 and 1 for any count from 1 to D.
- R3: `almost_empty_n` is 0 for counts 0 through n and 1 for counts above n, where n is the almost-empty offset.
- R4: `almost_full_n` is 1 for counts 0 through D-(m+1) and 0 for counts D-m through D, where m is the almost-full offset.
- R5: `full_n` is 0 only when the count equals D.
- R6: A cycle with `ofs_load`=1 loads `ofs_data[8:0]` into one offset register. `ofs_sel`=0 selects the almost-empty offset and `ofs_sel`=1 selects the almost-full offset. Bits 17 to 9 of `ofs_data` are ignored. The new value is used from the next cycle on.
- R7: With D=256, bit 8 of a loaded offset is forced to 0.
- R8: A push while full is ignored, and a pop while empty is ignored. Neither changes the count or the data.
- R9: A push and a pop in the same cycle, with the FIFO neither empty nor full, leave the count and flags unchanged. With the FIFO full, only the pop is accepted. With the FIFO empty, only the push is accepted.
- R10: Words leave in the order they were accepted. `dout` shows the popped word from the cycle after an accepted pop and holds its value at all other times.
- R11: The flags change in the cycle after the accepted push or pop that moves the count across a boundary.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| push | input | 1 | Write strobe for `din` |
| din | input | 18 | Write data |
| pop | input | 1 | Read strobe |
| dout | output | 18 | Registered read data |
| ofs_load | input | 1 | Offset register load strobe |
| ofs_sel | input | 1 | 0 = almost-empty offset, 1 = almost-full offset |
| ofs_data | input | 18 | Offset word; bits 8..0 are used |
| empty_n | output | 1 | Low when no words are held |
| almost_empty_n | output | 1 | Low when count <= almost-empty offset |
| almost_full_n | output | 1 | Low when count >= D - almost-full offset |
| full_n | output | 1 | Low when count equals D |

## Verification
A push and a pop can arrive in the same cycle. The bench provokes this at an empty, a partly filled and a full FIFO. A behavioural queue model decides which half is accepted, and the flags and `dout` are compared against that model every cycle. An offset load can also share a cycle with a push that crosses a boundary. The bench judges that case by checking that the new threshold, not the old one, governs the flags from the next cycle on.

// File: rtl/prog_flag_fifo_pkg.sv
package prog_flag_fifo_pkg;
    typedef enum logic [1:0] {
        ST_EMPTY   = 2'd0,
        ST_PARTIAL = 2'd1,
        ST_FULL    = 2'd2
    } fill_state_t;

    localparam int OFS_FIELD_W = 9;
    localparam int OFS_RESET   = 7;
endpackage

// File: rtl/pff_level.sv
module pff_level
    import prog_flag_fifo_pkg::*;
#(
    parameter int DEPTH = 256,
    localparam int CNT_W = $clog2(DEPTH) + 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push,
    input  logic             pop,
    output logic             push_ok,
    output logic             pop_ok,
    output logic [CNT_W-1:0] count
);
    localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);

    fill_state_t      state, state_nxt;
    logic [CNT_W-1:0] count_nxt;

    always_comb begin
        push_ok = 1'b0;
        pop_ok  = 1'b0;
        unique case (state)
            ST_EMPTY:   push_ok = push;
            ST_PARTIAL: begin
                push_ok = push;
                pop_ok  = pop;
            end
            ST_FULL:    pop_ok = pop;
            default:    ;
        endcase
    end

    always_comb begin
        count_nxt = count;
        if (push_ok && !pop_ok) count_nxt = count + 1'b1;
        else if (pop_ok && !push_ok) count_nxt = count - 1'b1;
    end

    always_comb begin
        state_nxt = state;
        unique case (state)
            ST_EMPTY:   if (push_ok) state_nxt = ST_PARTIAL;
            ST_PARTIAL: begin
                if (count_nxt == '0) state_nxt = ST_EMPTY;
                else if (count_nxt == FULL_CNT) state_nxt = ST_FULL;
            end
            ST_FULL:    if (pop_ok) state_nxt = ST_PARTIAL;
            default:    state_nxt = ST_EMPTY;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_EMPTY;
            count <= '0;
        end else begin
            state <= state_nxt;
            count <= count_nxt;
        end
    end
endmodule

// File: rtl/pff_store.sv
module pff_store #(
    parameter int DATA_W = 18,
    parameter int DEPTH  = 256,
    localparam int PTR_W = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              rd_en,
    output logic [DATA_W-1:0] rd_data
);
    logic [DATA_W-1:0] mem [DEPTH];
    logic [PTR_W-1:0]  wr_ptr, rd_ptr;

    always_ff @(posedge clk) begin
        if (wr_en) mem[wr_ptr] <= wr_data;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_ptr  <= '0;
            rd_ptr  <= '0;
            rd_data <= '0;
        end else begin
            if (wr_en) wr_ptr <= wr_ptr + 1'b1;
            if (rd_en) begin
                rd_ptr  <= rd_ptr + 1'b1;
                rd_data <= mem[rd_ptr];
            end
        end
    end
endmodule

// File: rtl/pff_offsets.sv
module pff_offsets
    import prog_flag_fifo_pkg::*;
#(
    parameter int DEPTH  = 256,
    parameter int WORD_W = 18,
    localparam int KEEP_W = $clog2(DEPTH)
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   load,
    input  logic                   sel,
    input  logic [WORD_W-1:0]      word,
    output logic [OFS_FIELD_W-1:0] ae_ofs,
    output logic [OFS_FIELD_W-1:0] af_ofs
);
    logic [OFS_FIELD_W-1:0] trimmed;

    generate
        if (KEEP_W < OFS_FIELD_W) begin : g_trim
            assign trimmed = {{(OFS_FIELD_W - KEEP_W){1'b0}}, word[KEEP_W-1:0]};
        end else begin : g_full
            assign trimmed = word[OFS_FIELD_W-1:0];
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ae_ofs <= OFS_FIELD_W'(OFS_RESET);
            af_ofs <= OFS_FIELD_W'(OFS_RESET);
        end else if (load) begin
            if (sel) af_ofs <= trimmed;
            else     ae_ofs <= trimmed;
        end
    end
endmodule

// File: rtl/pff_flags.sv
module pff_flags
    import prog_flag_fifo_pkg::*;
#(
    parameter int DEPTH = 256,
    localparam int CNT_W = $clog2(DEPTH) + 1,
    localparam int CMP_W = CNT_W + 1
) (
    input  logic [CNT_W-1:0]       count,
    input  logic [OFS_FIELD_W-1:0] ae_ofs,
    input  logic [OFS_FIELD_W-1:0] af_ofs,
    output logic                   empty_n,
    output logic                   almost_empty_n,
    output logic                   almost_full_n,
    output logic                   full_n
);
    localparam logic [CMP_W-1:0] DEPTH_C = CMP_W'(DEPTH);

    logic [CMP_W-1:0] cnt_c, ae_c, af_c;

    always_comb begin
        cnt_c          = CMP_W'(count);
        ae_c           = CMP_W'(ae_ofs);
        af_c           = CMP_W'(af_ofs);
        empty_n        = (cnt_c != '0);
        almost_empty_n = (cnt_c > ae_c);
        almost_full_n  = ((cnt_c + af_c) < DEPTH_C);
        full_n         = (cnt_c != DEPTH_C);
    end
endmodule

// File: rtl/prog_flag_fifo.sv
module prog_flag_fifo
    import prog_flag_fifo_pkg::*;
#(
    parameter int DATA_W = 18,
    parameter int DEPTH  = 256,
    parameter int WORD_W = 18
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              push,
    input  logic [DATA_W-1:0] din,
    input  logic              pop,
    output logic [DATA_W-1:0] dout,
    input  logic              ofs_load,
    input  logic              ofs_sel,
    input  logic [WORD_W-1:0] ofs_data,
    output logic              empty_n,
    output logic              almost_empty_n,
    output logic              almost_full_n,
    output logic              full_n
);
    localparam int CNT_W = $clog2(DEPTH) + 1;

    logic                   push_ok, pop_ok;
    logic [CNT_W-1:0]       count;
    logic [OFS_FIELD_W-1:0] ae_ofs, af_ofs;

    pff_level #(.DEPTH(DEPTH)) u_level (
        .clk(clk), .rst_n(rst_n), .push(push), .pop(pop),
        .push_ok(push_ok), .pop_ok(pop_ok), .count(count)
    );

    pff_store #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_store (
        .clk(clk), .rst_n(rst_n), .wr_en(push_ok), .wr_data(din),
        .rd_en(pop_ok), .rd_data(dout)
    );

    pff_offsets #(.DEPTH(DEPTH), .WORD_W(WORD_W)) u_offsets (
        .clk(clk), .rst_n(rst_n), .load(ofs_load), .sel(ofs_sel),
        .word(ofs_data), .ae_ofs(ae_ofs), .af_ofs(af_ofs)
    );

    pff_flags #(.DEPTH(DEPTH)) u_flags (
        .count(count), .ae_ofs(ae_ofs), .af_ofs(af_ofs),
        .empty_n(empty_n), .almost_empty_n(almost_empty_n),
        .almost_full_n(almost_full_n), .full_n(full_n)
    );
endmodule

// File: rtl/prog_flag_fifo_chk.sv
module prog_flag_fifo_chk #(
    parameter int DATA_W = 18
) (
    input logic              clk,
    input logic              rst_n,
    input logic              push,
    input logic              pop,
    input logic              ofs_load,
    input logic [DATA_W-1:0] dout,
    input logic              empty_n,
    input logic              almost_empty_n,
    input logic              almost_full_n,
    input logic              full_n
);
    a_r5_full_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (!full_n && push && !pop) |=> !full_n);

    a_r8_empty_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (!empty_n && pop && !push) |=> !empty_n);

    a_r11_first_push: assert property (@(posedge clk) disable iff (!rst_n)
        (!empty_n && push) |=> empty_n);

    a_r2_full_not_empty: assert property (@(posedge clk) disable iff (!rst_n)
        !full_n |-> empty_n);

    a_r9_balanced: assert property (@(posedge clk) disable iff (!rst_n)
        (push && pop && empty_n && full_n && !ofs_load)
        |=> $stable({empty_n, almost_empty_n, almost_full_n, full_n}));

    a_r10_dout_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !pop |=> $stable(dout));
endmodule

bind prog_flag_fifo prog_flag_fifo_chk #(.DATA_W(DATA_W)) u_chk (.*);

// File: tb/test_prog_flag_fifo.sv
`timescale 1ns/100ps
module test_prog_flag_fifo;
    localparam int D = 256;
    localparam int W = 18;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         push = 1'b0, pop = 1'b0, ofs_load = 1'b0, ofs_sel = 1'b0;
    logic [W-1:0] din = '0, ofs_data = '0;
    logic [W-1:0] dout;
    logic         empty_n, almost_empty_n, almost_full_n, full_n;

    int checks = 0, errors = 0;
    int q[$];
    int n_ofs = 7, m_ofs = 7;
    int m_dout = 0;
    int data_ctr = 1;
    string phase = "init";

    always #2.5 clk = ~clk;

    prog_flag_fifo #(.DATA_W(W), .DEPTH(D), .WORD_W(W)) i_prog_flag_fifo (
        .clk(clk), .rst_n(rst_n), .push(push), .din(din), .pop(pop),
        .dout(dout), .ofs_load(ofs_load), .ofs_sel(ofs_sel),
        .ofs_data(ofs_data), .empty_n(empty_n),
        .almost_empty_n(almost_empty_n), .almost_full_n(almost_full_n),
        .full_n(full_n)
    );

    task automatic check(string req, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s [%s] actual=%0d expected=%0d", req, phase, act, exp);
        end
    endtask

    task automatic compare_all();
        int sz = q.size();
        check("R2 empty_n", int'(empty_n), int'(sz != 0));
        check("R3 almost_empty_n", int'(almost_empty_n), int'(sz > n_ofs));
        check("R4 almost_full_n", int'(almost_full_n), int'(sz < D - m_ofs));
        check("R5 full_n", int'(full_n), int'(sz != D));
        check("R10 dout", int'(dout), m_dout);
    endtask

    // One clock: inputs already set; update model at the edge, compare at negedge (R11).
    task automatic cycle(bit p, bit r, bit ld = 0, bit sel = 0, int word = 0);
        bit push_ok, pop_ok;
        int v;
        push = p; pop = r; din = W'(data_ctr);
        ofs_load = ld; ofs_sel = sel; ofs_data = W'(word);
        @(posedge clk);
        push_ok = p && (q.size() < D);
        pop_ok  = r && (q.size() > 0);
        if (pop_ok) m_dout = q.pop_front();
        if (push_ok) q.push_back(data_ctr);
        if (p) data_ctr++;
        if (ld) begin
            v = word & 'h1FF;
            if (D == 256) v = v & 'hFF;   // R7 bit 8 dropped
            if (sel) m_ofs = v; else n_ofs = v;
        end
        @(negedge clk);
        push = 0; pop = 0; ofs_load = 0;
        compare_all();
    endtask

    task automatic sweep(string name);
        phase = name;
        for (int i = 0; i < D + 3; i++) cycle(1, 0);   // R8 last pushes at full ignored
        for (int i = 0; i < D + 3; i++) cycle(0, 1);   // R8 last pops at empty ignored
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        phase = "reset";
        check("R1 empty_n", int'(empty_n), 0);
        check("R1 almost_empty_n", int'(almost_empty_n), 0);
        check("R1 almost_full_n", int'(almost_full_n), 1);
        check("R1 full_n", int'(full_n), 1);
        check("R1 dout", int'(dout), 0);
        rst_n = 1'b1;
        @(negedge clk);

        sweep("R1 default offsets 7/7");

        phase = "R6 load 0/0";
        cycle(0, 0, 1, 0, 0);
        cycle(0, 0, 1, 1, 0);
        sweep("R6 offsets 0/0");

        phase = "R7 bit8 trim";
        cycle(0, 0, 1, 0, 'h3_0105);   // high junk + bit8 -> 5
        cycle(0, 0, 1, 1, 'h0_03C8);   // bit9, bit8 -> 200
        sweep("R7 offsets 5/200");

        phase = "R6 load 255/255";
        cycle(0, 0, 1, 0, 255);
        cycle(0, 0, 1, 1, 255);
        sweep("R6 offsets 255/255");

        phase = "R9 push+pop at empty";
        cycle(0, 0, 1, 0, 3);
        cycle(0, 0, 1, 1, 3);
        cycle(1, 1);
        cycle(1, 1);
        phase = "R9 push+pop mid";
        for (int i = 0; i < 10; i++) cycle(1, 0);
        for (int i = 0; i < 20; i++) cycle(1, 1);
        phase = "R9 push+pop at full";
        while (q.size() < D) cycle(1, 0);
        cycle(1, 1);
        cycle(1, 0);
        cycle(1, 1);

        phase = "R6 load with crossing push";
        while (q.size() > 0) cycle(0, 1);
        for (int i = 0; i < 3; i++) cycle(1, 0);
        cycle(1, 0, 1, 0, 10);          // new almost-empty offset lands with push
        for (int i = 0; i < 9; i++) cycle(1, 0);
        cycle(0, 1, 1, 1, 250);
        while (q.size() < D - 250) cycle(1, 0);
        cycle(1, 0);
        while (q.size() > 0) cycle(0, 1);
        cycle(0, 1);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule